// File: doc/BRIEF.md
# Selectable CAN Core Clock Generator

This block produces the protocol time-base for one CAN-FD channel. It runs entirely on a 240 MHz reference clock. It emits a one-cycle enable pulse at the selected protocol rate. A 4-bit selector register sits on a simple 32-bit register bus. The selector picks either the 80 MHz rate or one of five rates derived from 240 MHz by integer division. The 80 MHz rate is produced as one enable in every three reference cycles, so no second clock domain or analog clock switch is needed.

The block also reports the protocol frequency in effect, in MHz, and a flag that is raised when an unsupported divider code forced a fallback to the 80 MHz rate. A new selector value only takes hold when the enable period in progress has finished. Because of this, a rate change never produces a shortened or stretched period.

Top module: `ccg_core_clk_gen`

## Requirements
- R1: Synchronous active-high reset clears the selector to 0, sets `eff_mhz` to 80 and clears `fallback`. The first enable pulse appears at the second falling clock edge after reset is released.
- R2: With selector bit 3 at 0, the enable repeats every 3 cycles, `eff_mhz` is 80 and `fallback` is 0, whatever bits 2:0 hold.
- R3: With selector bit 3 at 1, divider codes 0, 1, 2, 3 and 4 in bits 2:0 give periods of 4, 6, 8, 10 and 12 cycles, and `eff_mhz` reads 60, 40, 30, 24 and 20 respectively.
- R4: With selector bit 3 at 1 and divider codes 5, 6 or 7, the enable repeats every 3 cycles, `eff_mhz` is 80 and `fallback` is 1.
- R5: The selector is at byte address (CHAN_IDX+1)*0x1000 + 0x08, which is 0x1008 for channel 0. A write stores `bus_wdata[3:0]`. A read sets `bus_rvalid` one cycle after the request, with the selector in `bus_rdata[3:0]` and zeros above.
- R6: A write to any other address changes neither the selector readback nor the enable period.
- R7: A selector change takes effect only at the end of the current enable period. `eff_mhz` and `fallback` change only on the edge that follows an enable pulse.
- R8: Every enable pulse is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 240 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| clk_en | output | 1 | Protocol clock enable pulse |
| eff_mhz | output | 8 | Protocol frequency in effect, in MHz |
| fallback | output | 1 | Unsupported divider code replaced by 80 MHz |

## Verification
The bench writes a new rate on the exact cycle that closes a long period. A design that reloads its counter from the freshly written value would then cut that 12-cycle period to 4 cycles, or change `eff_mhz` mid-period. It sweeps all five divide codes and the three unsupported ones. A wrong ratio table shows up as a measured period that is off, and a missing fallback shows up as a period of 4+2*code or as `fallback` staying at 0. Selector values with the source bit clear but nonzero divider bits check that the divider is ignored for the 80 MHz source. Writes into the neighbouring channel window and to a nearby offset check that the address decode rejects them.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    localparam int SEL_W      = 4;
    localparam int DIV_W      = 3;
    localparam int RATIO_W    = 4;
    localparam int MHZ_W      = 8;
    localparam int REF_MHZ    = 240;
    localparam int BASE_RATIO = 3;
    localparam int MAX_CODE   = 4;

    typedef enum logic {
        SRC_80  = 1'b0,
        SRC_240 = 1'b1
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [DIV_W-1:0] div;
    } sel_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [MHZ_W-1:0]   mhz;
        logic               fallback;
    } rate_t;

    function automatic rate_t decode_rate(input sel_t s);
        rate_t r;
        r.ratio    = RATIO_W'(BASE_RATIO);
        r.mhz      = MHZ_W'(REF_MHZ / BASE_RATIO);
        r.fallback = 1'b0;
        if (s.src == SRC_240) begin
            if (int'(s.div) <= MAX_CODE) begin
                r.ratio = RATIO_W'(4 + 2 * int'(s.div));
                case (s.div)
                    3'd0:    r.mhz = MHZ_W'(REF_MHZ / 4);
                    3'd1:    r.mhz = MHZ_W'(REF_MHZ / 6);
                    3'd2:    r.mhz = MHZ_W'(REF_MHZ / 8);
                    3'd3:    r.mhz = MHZ_W'(REF_MHZ / 10);
                    default: r.mhz = MHZ_W'(REF_MHZ / 12);
                endcase
            end else begin
                r.fallback = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ccg_regif.sv
module ccg_regif
    import ccg_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output sel_t              sel_q
);

    logic hit;
    logic wdata_unused;

    assign hit          = bus_sel && (bus_addr == REG_ADDR);
    assign wdata_unused = ^bus_wdata[DATA_W-1:SEL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            bus_rdata  <= '0;
            if (hit && bus_wr) begin
                sel_q <= sel_t'(bus_wdata[SEL_W-1:0]);
            end
            if (hit && !bus_wr) begin
                bus_rdata <= {{(DATA_W-SEL_W){1'b0}}, sel_q};
            end
        end
    end

endmodule

// File: rtl/ccg_rate_map.sv
module ccg_rate_map
    import ccg_pkg::*;
(
    input  sel_t  sel,
    output rate_t rate
);

    always_comb begin
        rate = decode_rate(sel);
    end

endmodule

// File: rtl/ccg_pulse_gen.sv
module ccg_pulse_gen
    import ccg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_t next_rate,
    output logic  clk_en,
    output rate_t active
);

    localparam rate_t RESET_RATE = decode_rate(sel_t'('0));

    logic [RATIO_W-1:0] cnt;

    assign clk_en = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= RESET_RATE.ratio - RATIO_W'(1);
            active <= RESET_RATE;
        end else if (cnt == '0) begin
            cnt    <= next_rate.ratio - RATIO_W'(1);
            active <= next_rate;
        end else begin
            cnt <= cnt - RATIO_W'(1);
        end
    end

endmodule

// File: rtl/ccg_core_clk_gen.sv
module ccg_core_clk_gen
    import ccg_pkg::*;
#(
    parameter int CHAN_IDX   = 0,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WIN_STRIDE = 'h1000,
    parameter int SEL_OFFSET = 'h8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              clk_en,
    output logic [MHZ_W-1:0]  eff_mhz,
    output logic              fallback
);

    localparam logic [ADDR_W-1:0] REG_ADDR =
        ADDR_W'((CHAN_IDX + 1) * WIN_STRIDE + SEL_OFFSET);

    sel_t  sel_q;
    rate_t next_rate;
    rate_t active;

    ccg_regif #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .sel_q     (sel_q)
    );

    ccg_rate_map u_map (
        .sel (sel_q),
        .rate(next_rate)
    );

    ccg_pulse_gen u_pulse (
        .clk      (clk),
        .rst      (rst),
        .next_rate(next_rate),
        .clk_en   (clk_en),
        .active   (active)
    );

    assign eff_mhz  = active.mhz;
    assign fallback = active.fallback;

endmodule

// File: rtl/ccg_checker.sv
module ccg_checker
    import ccg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rvalid,
    input logic             clk_en,
    input logic [MHZ_W-1:0] eff_mhz,
    input logic             fallback
);

    logic [4:0] gap;
    logic       seen;

    function automatic logic [4:0] ratio_for(input logic [MHZ_W-1:0] m);
        case (m)
            8'd60:   return 5'd4;
            8'd40:   return 5'd6;
            8'd30:   return 5'd8;
            8'd24:   return 5'd10;
            8'd20:   return 5'd12;
            default: return 5'd3;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            seen <= seen | clk_en;
            if (clk_en)          gap <= 5'd1;
            else if (gap != '1)  gap <= gap + 5'd1;
        end
    end

    AST_RESET_RATE: assert property (@(posedge clk)
        rst |=> (eff_mhz == 8'd80) && !fallback);                     // R1

    AST_FALLBACK_RATE: assert property (@(posedge clk) disable iff (rst)
        fallback |-> eff_mhz == 8'd80);                               // R4

    AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (rst)
        (clk_en && seen) |-> gap == ratio_for(eff_mhz));              // R7

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(eff_mhz) && $stable(fallback));           // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> !clk_en);                                          // R8

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid);                         // R5

endmodule

bind ccg_core_clk_gen ccg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rvalid(bus_rvalid),
    .clk_en    (clk_en),
    .eff_mhz   (eff_mhz),
    .fallback  (fallback)
);

// File: tb/sim_ccg_core_clk_gen.sv
module sim_ccg_core_clk_gen;

    localparam logic [15:0] REG = 16'h1008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        clk_en;
    logic [7:0]  eff_mhz;
    logic        fallback;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ccg_core_clk_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .clk_en    (clk_en),
        .eff_mhz   (eff_mhz),
        .fallback  (fallback)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d, output logic v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en && n < 64);
    endtask

    task automatic expect_sel(input int exp, input string req);
        logic [31:0] d;
        logic v;
        bus_read(REG, d, v);
        check(v == 1'b1, req, int'(v), 1);
        check(d == 32'(exp), req, int'(d), exp);
    endtask

    task automatic run_rate(input logic [31:0] val, input int ratio, input int mhz,
                            input bit fb, input string req);
        int n;
        bus_write(REG, val);
        wait_pulse(n);
        wait_pulse(n);
        check(n == ratio, req, n, ratio);
        check(int'(eff_mhz) == mhz, req, int'(eff_mhz), mhz);
        check(fallback == fb, req, int'(fallback), int'(fb));
        @(negedge clk);
        check(clk_en == 1'b0, "R8", int'(clk_en), 0);
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(eff_mhz == 8'd80, "R1", int'(eff_mhz), 80);
        check(fallback == 1'b0, "R1", int'(fallback), 0);
        check(clk_en == 1'b0, "R1", int'(clk_en), 0);
        wait_pulse(n);
        check(n == 2, "R1", n, 2);
        expect_sel(0, "R1");
    endtask

    task automatic t_src80;
        run_rate(32'h7, 3, 80, 1'b0, "R2");
        expect_sel(7, "R2");
        run_rate(32'h2, 3, 80, 1'b0, "R2");
    endtask

    task automatic t_div240;
        for (int c = 0; c <= 4; c++) begin
            run_rate(32'(8 + c), 4 + 2 * c, 240 / (4 + 2 * c), 1'b0, "R3");
        end
    endtask

    task automatic t_fallback;
        for (int c = 5; c <= 7; c++) begin
            run_rate(32'(8 + c), 3, 80, 1'b1, "R4");
        end
    endtask

    task automatic t_decode;
        int n;
        run_rate(32'hFFFF_FFF9, 6, 40, 1'b0, "R5");
        expect_sel(9, "R5");
        bus_write(16'h2008, 32'hC);
        bus_write(16'h1004, 32'hC);
        bus_write(16'h0008, 32'hC);
        expect_sel(9, "R6");
        wait_pulse(n);
        wait_pulse(n);
        check(n == 6, "R6", n, 6);
        check(eff_mhz == 8'd40, "R6", int'(eff_mhz), 40);
    endtask

    task automatic t_boundary;
        int n;
        run_rate(32'hC, 12, 20, 1'b0, "R7");
        wait_pulse(n);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = REG; bus_wdata = 32'h8;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        n = 1;
        check(eff_mhz == 8'd20, "R7", int'(eff_mhz), 20);
        while (!clk_en && n < 64) begin
            @(negedge clk);
            n++;
        end
        check(n == 12, "R7", n, 12);
        check(eff_mhz == 8'd20, "R7", int'(eff_mhz), 20);
        wait_pulse(n);
        check(n == 4, "R7", n, 4);
        check(eff_mhz == 8'd60, "R7", int'(eff_mhz), 60);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_src80();
        t_div240();
        t_fallback();
        t_decode();
        t_boundary();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule